// File: doc/BRIEF.md
# Flash Command Sequence Guard

This block sits on the device side of a byte-wide flash bus. It watches every bus write (address, data and a write strobe) and lets the storage array change only after a fixed unlock sequence has been recognised. A three-write unlock arms a single-byte program. The next write then supplies the target address and data, and the block issues a one-cycle program start. A six-write sequence arms an erase of either the whole array or one sector. The same unlock also enters an identification mode, in which reads return a maker code and a device code. A matching exit command leaves that mode.

Each write is taken on the rising edge of the write strobe, sampled by the block clock. A write that does not match the next expected cycle drops the block back to plain read mode, and it also leaves identification mode. While the array reports an operation in progress, every write is ignored. Reset and exit commands are ignored then too. The array itself and its timing are outside this block.

Top module: `flash_cmd_guard`

## Requirements
- R1: After reset, id_mode is 0, id_data is 0x00, no start pulse is raised, and the decoder expects the first unlock cycle.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, followed by any write, raise prog_start for exactly one cycle. The pulse rises in the cycle after the clock edge that samples the strobe rise of that last write. prog_addr and prog_data hold that write's address and data.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x10@0x5555 raise erase_start for one cycle with erase_chip=1.
- R4: The same five setup writes followed by 0x30 at any address raise erase_start for one cycle with erase_chip=0. erase_addr equals that address with its low SECT_W bits (12 by default) cleared.
- R5: A write that does not match the expected next cycle returns the decoder to the first unlock cycle and clears id_mode. It raises no pulse, and it is not reused as a first unlock cycle.
- R6: The unlock writes with command 0x90 set id_mode. While id_mode is 1, id_data is 0xBF for rd_addr 0, DEV_CODE (0xB5 by default) for rd_addr 1, and 0x00 for any other address. While id_mode is 0, id_data is 0x00.
- R7: The unlock writes with command 0xF0 clear id_mode. Outside identification mode, this sequence has no other effect.
- R8: A write whose strobe rise is sampled while op_busy is 1 is ignored. It leaves the sequence position and id_mode unchanged and raises no pulse. This holds for exit commands as well.
- R9: Only a rising strobe edge counts as a write. Holding wr_en high for several cycles is one write.
- R10: In identification mode, a third unlock cycle carrying 0xA0 or 0x80 is a mismatch, so it aborts to read mode as in R5.
- R11: Command addresses are compared on address bits [14:0] only. The upper address bits are ignored for unlock and command cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe; its rising edge takes a write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| op_busy | input | 1 | Array reports a program or erase in progress |
| rd_addr | input | ADDR_W | Read address for identification codes |
| prog_start | output | 1 | One-cycle program start |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_start | output | 1 | One-cycle erase start |
| erase_chip | output | 1 | 1 for whole-array erase, 0 for sector erase |
| erase_addr | output | ADDR_W | Sector base address (0 for chip erase) |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification read data |

## Verification
The sequence position cannot be seen directly at the ports. A wrong position therefore shows up as a data write that should have raised prog_start, or one that should not have. It can also show up as an erase that fires early or never fires. Such an error appears in the cycle after the strobe edge of the write that closes the sequence, which may be several writes after the fault. A wrong identification flag shows in id_mode and id_data in the cycle after the offending write. The bench therefore checks the pulses and id_mode after every single write, and runs long random mixes of partial, corrupted and busy-time writes, so that a stray position is soon exposed by the next write.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] UNLK_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] UNLK_ADDR_B = 15'h2AAA;
    localparam logic [7:0] UNLK_DATA_A = 8'hAA;
    localparam logic [7:0] UNLK_DATA_B = 8'h55;

    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_ID_EXIT  = 8'hF0;
    localparam logic [7:0] OP_CHIP_ER  = 8'h10;
    localparam logic [7:0] OP_SECT_ER  = 8'h30;

    localparam logic [7:0] MAKER_CODE = 8'hBF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNLK1,
        SQ_UNLK2,
        SQ_PROG_DATA,
        SQ_ER_SETUP,
        SQ_ER_UNLK1,
        SQ_ER_UNLK2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       id;
    } seq_ctx_t;

    function automatic logic beat_is(input logic [CMD_AW-1:0] a,
                                     input logic [7:0] d,
                                     input logic [CMD_AW-1:0] ea,
                                     input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fcg_strobe_edge.sv
module fcg_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/fcg_id_mux.sv
module fcg_id_mux #(
    parameter int          ADDR_W   = 17,
    parameter logic [7:0]  DEV_CODE = 8'hB5
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_data
);
    import fcg_pkg::*;

    always_comb begin
        id_data = 8'h00;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))      id_data = MAKER_CODE;
            else if (rd_addr == ADDR_W'(1)) id_data = DEV_CODE;
        end
    end
endmodule

// File: rtl/fcg_seq_fsm.sv
module fcg_seq_fsm #(
    parameter int ADDR_W = 17,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_start,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              id_mode
);
    import fcg_pkg::*;

    localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_W) - ADDR_W'(1));

    seq_ctx_t cur, nxt;
    logic do_prog, do_chip, do_sect;
    logic [CMD_AW-1:0] lo;

    assign lo = addr[CMD_AW-1:0];

    always_comb begin
        nxt     = cur;
        do_prog = 1'b0;
        do_chip = 1'b0;
        do_sect = 1'b0;
        if (fire && !busy) begin
            nxt.st = SQ_IDLE;
            nxt.id = 1'b0;
            unique case (cur.st)
                SQ_IDLE: begin
                    if (beat_is(lo, data, UNLK_ADDR_A, UNLK_DATA_A))
                        nxt = '{SQ_UNLK1, cur.id};
                end
                SQ_UNLK1: begin
                    if (beat_is(lo, data, UNLK_ADDR_B, UNLK_DATA_B))
                        nxt = '{SQ_UNLK2, cur.id};
                end
                SQ_UNLK2: begin
                    if (lo == UNLK_ADDR_A) begin
                        if (data == OP_PROGRAM && !cur.id)
                            nxt = '{SQ_PROG_DATA, 1'b0};
                        else if (data == OP_ERASE && !cur.id)
                            nxt = '{SQ_ER_SETUP, 1'b0};
                        else if (data == OP_ID_ENTER)
                            nxt = '{SQ_IDLE, 1'b1};
                    end
                end
                SQ_PROG_DATA: do_prog = 1'b1;
                SQ_ER_SETUP: begin
                    if (beat_is(lo, data, UNLK_ADDR_A, UNLK_DATA_A))
                        nxt = '{SQ_ER_UNLK1, 1'b0};
                end
                SQ_ER_UNLK1: begin
                    if (beat_is(lo, data, UNLK_ADDR_B, UNLK_DATA_B))
                        nxt = '{SQ_ER_UNLK2, 1'b0};
                end
                SQ_ER_UNLK2: begin
                    if (beat_is(lo, data, UNLK_ADDR_A, OP_CHIP_ER)) do_chip = 1'b1;
                    else if (data == OP_SECT_ER)                    do_sect = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= '{SQ_IDLE, 1'b0};
            prog_start  <= 1'b0;
            prog_addr   <= '0;
            prog_data   <= '0;
            erase_start <= 1'b0;
            erase_chip  <= 1'b0;
            erase_addr  <= '0;
        end else begin
            cur         <= nxt;
            prog_start  <= do_prog;
            erase_start <= do_chip | do_sect;
            if (do_prog) begin
                prog_addr <= addr;
                prog_data <= data;
            end
            if (do_chip) begin
                erase_chip <= 1'b1;
                erase_addr <= '0;
            end else if (do_sect) begin
                erase_chip <= 1'b0;
                erase_addr <= addr & SECT_MASK;
            end
        end
    end

    assign id_mode = cur.id;
endmodule

// File: rtl/flash_cmd_guard.sv
module flash_cmd_guard #(
    parameter int         ADDR_W   = 17,
    parameter int         SECT_W   = 12,
    parameter logic [7:0] DEV_CODE = 8'hB5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_start,
    output logic              erase_chip,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              id_mode,
    output logic [7:0]        id_data
);
    logic wr_fire;

    fcg_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (wr_en),
        .rise   (wr_fire)
    );

    fcg_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .fire        (wr_fire),
        .busy        (op_busy),
        .addr        (wr_addr),
        .data        (wr_data),
        .prog_start  (prog_start),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .erase_start (erase_start),
        .erase_chip  (erase_chip),
        .erase_addr  (erase_addr),
        .id_mode     (id_mode)
    );

    fcg_id_mux #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );
endmodule

// File: rtl/flash_cmd_guard_chk.sv
module flash_cmd_guard_chk #(
    parameter int ADDR_W = 17,
    parameter int SECT_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              op_busy,
    input logic              prog_start,
    input logic              erase_start,
    input logic              erase_chip,
    input logic [ADDR_W-1:0] erase_addr,
    input logic              id_mode,
    input logic [7:0]        id_data
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << SECT_W) - ADDR_W'(1);

    AST_START_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(prog_start && erase_start)); // R2

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start); // R2

    AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start); // R3

    AST_SECT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (erase_start && !erase_chip) |-> ((erase_addr & LOW_MASK) == '0)); // R4

    AST_CHIP_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (erase_start && erase_chip) |-> (erase_addr == '0)); // R3

    AST_ID_QUIET: assert property (@(posedge clk) disable iff (rst)
        !id_mode |-> (id_data == 8'h00)); // R6

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        op_busy |=> (!prog_start && !erase_start)); // R8

    AST_BUSY_ID_HELD: assert property (@(posedge clk) disable iff (rst)
        op_busy |=> $stable(id_mode)); // R8

    AST_NO_STROBE_NO_START: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!prog_start && !erase_start)); // R9

    AST_NO_STROBE_ID_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(id_mode)); // R9
endmodule

bind flash_cmd_guard flash_cmd_guard_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .op_busy     (op_busy),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .erase_chip  (erase_chip),
    .erase_addr  (erase_addr),
    .id_mode     (id_mode),
    .id_data     (id_data)
);

// File: tb/flash_cmd_guard_tb.sv
module flash_cmd_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam logic [7:0] DEVC = 8'hB5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          op_busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prog_start, erase_start, erase_chip, id_mode;
    logic [AW-1:0] prog_addr, erase_addr;
    logic [7:0]    prog_data, id_data;

    int n_chk = 0;
    int n_bad = 0;
    int m_st = 0;
    bit m_id = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_guard u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_busy(op_busy), .rd_addr(rd_addr), .prog_start(prog_start),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_start(erase_start),
        .erase_chip(erase_chip), .erase_addr(erase_addr), .id_mode(id_mode),
        .id_data(id_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_id(input bit idm, input logic [AW-1:0] a);
        if (!idm) return 8'h00;
        if (a == 0) return 8'hBF;
        if (a == 1) return DEVC;
        return 8'h00;
    endfunction

    // reference model from the requirements
    task automatic model(input logic [AW-1:0] a, input logic [7:0] d,
                         output bit ep, output bit ee, output bit ec,
                         output logic [AW-1:0] ea);
        logic [14:0] lo;
        bit ok;
        lo = a[14:0];
        ep = 0; ee = 0; ec = 0; ea = '0;
        ok = 1'b0;
        case (m_st)
            0: if (lo == 15'h5555 && d == 8'hAA) begin m_st = 1; ok = 1; end
            1: if (lo == 15'h2AAA && d == 8'h55) begin m_st = 2; ok = 1; end
            2: if (lo == 15'h5555) begin
                   if (d == 8'hA0 && !m_id)      begin m_st = 3; ok = 1; end
                   else if (d == 8'h80 && !m_id) begin m_st = 4; ok = 1; end
                   else if (d == 8'h90)          begin m_st = 0; m_id = 1; ok = 1; end
                   else if (d == 8'hF0)          begin m_st = 0; m_id = 0; ok = 1; end
               end
            3: begin ep = 1; m_st = 0; ok = 1; end
            4: if (lo == 15'h5555 && d == 8'hAA) begin m_st = 5; ok = 1; end
            5: if (lo == 15'h2AAA && d == 8'h55) begin m_st = 6; ok = 1; end
            6: begin
                   if (lo == 15'h5555 && d == 8'h10) begin ee = 1; ec = 1; ok = 1; end
                   else if (d == 8'h30) begin ee = 1; ea = {a[AW-1:12], 12'h000}; ok = 1; end
                   m_st = 0;
               end
            default: ;
        endcase
        if (!ok) begin m_st = 0; m_id = 0; end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                            input bit busy, input int hold, input string req);
        bit ep, ee, ec;
        logic [AW-1:0] ea;
        int np, ne;
        logic [AW-1:0] gpa, gea;
        logic [7:0] gpd;
        logic gec;
        ep = 0; ee = 0; ec = 0; ea = '0;
        if (!busy) model(a, d, ep, ee, ec, ea);
        np = 0; ne = 0; gpa = '0; gpd = '0; gea = '0; gec = 0;
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1; op_busy = busy;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (prog_start)  begin np++; gpa = prog_addr; gpd = prog_data; end
            if (erase_start) begin ne++; gea = erase_addr; gec = erase_chip; end
        end
        wr_en = 1'b0;
        @(negedge clk);
        if (prog_start) np++;
        if (erase_start) ne++;
        op_busy = 1'b0;
        chk(np == (ep ? 1 : 0), {req, " prog pulse count"}, np, ep);
        chk(ne == (ee ? 1 : 0), {req, " erase pulse count"}, ne, ee);
        if (ep) begin
            chk(gpa == a, {req, " prog_addr"}, gpa, a);
            chk(gpd == d, {req, " prog_data"}, gpd, d);
        end
        if (ee) begin
            chk(gec == ec, {req, " erase_chip"}, gec, ec);
            chk(gea == ea, {req, " erase_addr"}, gea, ea);
        end
        chk(id_mode == m_id, {req, " id_mode"}, id_mode, m_id);
    endtask

    task automatic unlock(input logic [7:0] cmd, input string req);
        do_write(17'h05555, 8'hAA, 0, 1, req);
        do_write(17'h02AAA, 8'h55, 0, 1, req);
        do_write(17'h05555, cmd, 0, 1, req);
    endtask

    task automatic check_id(input logic [AW-1:0] a, input string req);
        rd_addr = a;
        #1;
        chk(id_data == exp_id(m_id, a), req, id_data, exp_id(m_id, a));
    endtask

    function automatic logic [AW-1:0] cmd_addr(input logic [14:0] lo);
        return {2'($urandom_range(0, 3)), lo};
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(id_mode == 1'b0, "R1 id_mode after reset", id_mode, 0);
        chk(prog_start == 1'b0 && erase_start == 1'b0, "R1 no pulse after reset",
            {prog_start, erase_start}, 0);
        check_id(17'h0, "R1 id_data after reset");

        // R2: program
        unlock(8'hA0, "R2");
        do_write(17'h1ABCD, 8'h3C, 0, 1, "R2 data");
        // R3: chip erase
        unlock(8'h80, "R3");
        do_write(17'h05555, 8'hAA, 0, 1, "R3");
        do_write(17'h02AAA, 8'h55, 0, 1, "R3");
        do_write(17'h05555, 8'h10, 0, 1, "R3 final");
        // R4 + R11: sector erase, upper address bits set
        unlock(8'h80, "R4");
        do_write(17'h15555, 8'hAA, 0, 1, "R11 upper bits");
        do_write(17'h12AAA, 8'h55, 0, 1, "R11 upper bits");
        do_write(17'h13FFF, 8'h30, 0, 1, "R4 sector");
        // R5: mismatch aborts and is not reused
        do_write(17'h05555, 8'hAA, 0, 1, "R5");
        do_write(17'h05555, 8'hAA, 0, 1, "R5 wrong second cycle");
        do_write(17'h02AAA, 8'h55, 0, 1, "R5");
        do_write(17'h05555, 8'hA0, 0, 1, "R5");
        do_write(17'h00100, 8'h77, 0, 1, "R5 no program after abort");
        // R6: ID entry and reads
        unlock(8'h90, "R6 entry");
        check_id(17'h0, "R6 maker code");
        check_id(17'h1, "R6 device code");
        check_id(17'h2, "R6 other address");
        // R10: program command in ID mode aborts
        unlock(8'hA0, "R10 A0 in id mode");
        check_id(17'h0, "R10 id_data after abort");
        // R8: busy exit ignored, then real exit (R7)
        unlock(8'h90, "R6 re-entry");
        do_write(17'h05555, 8'hAA, 0, 1, "R8");
        do_write(17'h02AAA, 8'h55, 0, 1, "R8");
        do_write(17'h05555, 8'hF0, 1, 1, "R8 exit while busy");
        check_id(17'h1, "R8 still in id mode");
        do_write(17'h05555, 8'hF0, 0, 1, "R7 exit");
        check_id(17'h0, "R7 id_data after exit");
        unlock(8'hF0, "R7 exit outside id mode");
        // R8: busy write mid-sequence leaves position
        do_write(17'h05555, 8'hAA, 0, 1, "R8");
        do_write(17'h00000, 8'h00, 1, 1, "R8 garbage while busy");
        do_write(17'h02AAA, 8'h55, 0, 1, "R8");
        do_write(17'h05555, 8'hA0, 0, 1, "R8");
        do_write(17'h00042, 8'h99, 0, 1, "R8 program after busy write");
        // R9: held strobe is one write
        unlock(8'hA0, "R9");
        do_write(17'h00777, 8'h5A, 0, 4, "R9 held data strobe");
        do_write(17'h05555, 8'hAA, 0, 3, "R9 held unlock");
        do_write(17'h02AAA, 8'h55, 0, 5, "R9 held unlock");
        do_write(17'h05555, 8'hA0, 0, 2, "R9");
        do_write(17'h00778, 8'h5B, 0, 1, "R9 data");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int kind;
            logic [7:0] cmds [5];
            cmds = '{8'hA0, 8'h80, 8'h90, 8'hF0, 8'h33};
            kind = $urandom_range(0, 4);
            for (int s = 0; s < 7; s++) begin
                logic [AW-1:0] a;
                logic [7:0] d;
                bit busy;
                case (s)
                    0, 3: begin a = cmd_addr(15'h5555); d = 8'hAA; end
                    1, 4: begin a = cmd_addr(15'h2AAA); d = 8'h55; end
                    2: begin a = cmd_addr(15'h5555); d = cmds[kind]; end
                    5: begin
                           a = ($urandom_range(0, 1) != 0) ? cmd_addr(15'h5555) : AW'($urandom);
                           d = ($urandom_range(0, 1) != 0) ? 8'h10 : 8'h30;
                       end
                    default: begin a = AW'($urandom); d = 8'($urandom); end
                endcase
                if ($urandom_range(0, 9) == 0) d = 8'($urandom);
                if ($urandom_range(0, 15) == 0) a = AW'($urandom);
                busy = ($urandom_range(0, 11) == 0);
                do_write(a, d, busy, $urandom_range(1, 2), "R2/R3/R4/R5/R8 random");
                if (s == 2 && kind >= 2) break;
                if (s == 3 && kind == 0) break;
            end
            check_id(AW'($urandom_range(0, 3)), "R6 random id read");
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule